// File: doc/BRIEF.md
# PPS-Aligned Sample Timestamp Counter

This block keeps a wide timestamp in the sample clock domain. The timestamp moves forward by one on every cycle where the sample-valid strobe is high. A one-pulse-per-second signal from an external pin enters through a synchronizer, and only its rising edge is used. The result is a single word that other logic compares against scheduled start times. Host software reads the timestamp and chooses a future value at which transmission should begin.

There are two modes. In seconds-tag mode the upper half of the word counts PPS edges and the lower half counts samples within the current second. In armed-reset mode the whole word is one sample counter. A reset request arms the block, and the counter clears on the first PPS edge after that, so counting starts on a known second boundary.

The arming control is a two-state machine. In `ST_IDLE` the block waits. The transition *arm* (armed-reset mode and `clr_req` high) moves it to `ST_ARMED`. From `ST_ARMED`, the transition *fire* (a PPS edge in armed-reset mode) clears the counter and returns to `ST_IDLE`. The transition *abandon* (the mode switches to seconds-tag) also returns to `ST_IDLE`, but leaves the counter alone.

Top module: `pps_stamp_counter`

## Requirements
- R1: After reset, `stamp` is 0, `pps_seen` is 0 and `armed` is 0.
- R2: A rising edge on `pps_pin` makes `pps_seen` high for exactly one cycle. It goes high after the second rising clock edge that samples the pin high, and that PPS edge takes effect on `stamp` at the third edge. A pin held high gives only one pulse.
- R3: With `mode_sel`=0 (seconds-tag), a PPS edge adds one to `stamp[TS_W-1:TS_W/2]` and sets `stamp[TS_W/2-1:0]` to 0.
- R4: When no PPS action applies, `stamp` advances by exactly one in a cycle with `sample_vld` high and holds in a cycle with it low.
- R5: In seconds-tag mode, a PPS edge in the same cycle as a sample strobe leaves the lower half at 0, not 1.
- R6: With `mode_sel`=1 (armed-reset), `clr_req` raises `armed` and does not clear the counter. On the first PPS edge after that, the whole `stamp` becomes 0 (even if a sample strobe arrives in the same cycle) and `armed` falls.
- R7: `clr_req` has no effect while `armed` is already high or while in seconds-tag mode. In armed-reset mode, a PPS edge with `armed` low leaves `stamp` unchanged.
- R8: In armed-reset mode the lower half carries into the upper half when it wraps. In seconds-tag mode the lower half wraps to 0 and the upper half does not change.
- R9: Switching to seconds-tag mode drops `armed`. A mode change keeps the current `stamp` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Sample strobe; the counter advances on cycles where it is high |
| pps_pin | input | 1 | Asynchronous one-pulse-per-second input |
| mode_sel | input | 1 | 0 = seconds-tag, 1 = armed-reset |
| clr_req | input | 1 | Request to arm the PPS-aligned clear |
| stamp | output | TS_W | Current timestamp |
| pps_seen | output | 1 | One-cycle pulse for each synchronized PPS rising edge |
| armed | output | 1 | High while a clear is waiting for a PPS edge |

## Verification
The hardest cases to reach are the ones where a half-word wraps: the carry from the lower half in armed-reset mode and the plain wrap in seconds-tag mode. At the default width these would need billions of samples. The bench therefore builds the block with a 16-bit word and runs 300 back-to-back strobes, which crosses the 8-bit boundary in both modes. The bench also predicts the synchronizer delay from its own record of the pin's history. This lets it place PPS edges exactly on strobe cycles, on a request cycle, and on cycles just before and just after a mode switch.

// File: rtl/pps_stamp_pkg.sv
package pps_stamp_pkg;

    typedef enum logic {
        MODE_SECS   = 1'b0,
        MODE_ARMRST = 1'b1
    } stamp_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Chain of synchronizing flops; the depth comes from the parameter
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pps_arm_fsm.sv
module pps_arm_fsm
    import pps_stamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_armrst_i,
    input  logic clr_req_i,
    input  logic pps_edge_i,
    output logic armed_o,
    output logic fire_o
);
    arm_state_e state_q;
    arm_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_armrst_i && clr_req_i) state_d = ST_ARMED;      // arm
            end
            ST_ARMED: begin
                if (!mode_armrst_i)  state_d = ST_IDLE;                 // abandon
                else if (pps_edge_i) state_d = ST_IDLE;                 // fire
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        armed_o = 1'b0;
        fire_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                armed_o = 1'b0;
                fire_o  = 1'b0;
            end
            ST_ARMED: begin
                armed_o = 1'b1;
                fire_o  = mode_armrst_i & pps_edge_i;
            end
            default: begin
                armed_o = 1'b0;
                fire_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pps_stamp_core.sv
module pps_stamp_core #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_armrst_i,
    input  logic            sample_vld_i,
    input  logic            pps_edge_i,
    input  logic            fire_i,
    output logic [TS_W-1:0] stamp_o
);
    localparam int HALF = TS_W / 2;

    logic [HALF-1:0] up_q, up_d;
    logic [HALF-1:0] lo_q, lo_d;

    always_comb begin
        up_d = up_q;
        lo_d = lo_q;
        if (!mode_armrst_i) begin
            // seconds-tag: the upper half counts PPS edges, the lower half counts samples
            if (pps_edge_i) begin
                up_d = up_q + HALF'(1);
                lo_d = '0;
            end else if (sample_vld_i) begin
                lo_d = lo_q + HALF'(1);
            end
        end else begin
            // armed-reset: one full-width sample counter
            if (fire_i) begin
                up_d = '0;
                lo_d = '0;
            end else if (sample_vld_i) begin
                {up_d, lo_d} = {up_q, lo_q} + TS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= '0;
            lo_q <= '0;
        end else begin
            up_q <= up_d;
            lo_q <= lo_d;
        end
    end

    assign stamp_o = {up_q, lo_q};

endmodule

// File: rtl/pps_stamp_counter.sv
module pps_stamp_counter
    import pps_stamp_pkg::*;
#(
    parameter int TS_W        = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_vld,
    input  logic            pps_pin,
    input  logic            mode_sel,
    input  logic            clr_req,
    output logic [TS_W-1:0] stamp,
    output logic            pps_seen,
    output logic            armed
);
    stamp_mode_e mode;
    logic        mode_armrst;
    logic        pps_edge;
    logic        fire;

    assign mode        = stamp_mode_e'(mode_sel);
    assign mode_armrst = (mode == MODE_ARMRST);

    pps_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pps_pin),
        .rise_o (pps_edge)
    );

    pps_arm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_armrst_i (mode_armrst),
        .clr_req_i     (clr_req),
        .pps_edge_i    (pps_edge),
        .armed_o       (armed),
        .fire_o        (fire)
    );

    pps_stamp_core #(
        .TS_W (TS_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_armrst_i (mode_armrst),
        .sample_vld_i  (sample_vld),
        .pps_edge_i    (pps_edge),
        .fire_i        (fire),
        .stamp_o       (stamp)
    );

    assign pps_seen = pps_edge;

endmodule

// File: rtl/pps_stamp_checker.sv
module pps_stamp_checker #(
    parameter int TS_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sample_vld,
    input logic            mode_sel,
    input logic            clr_req,
    input logic [TS_W-1:0] stamp,
    input logic            pps_seen,
    input logic            armed
);
    localparam int HALF = TS_W / 2;

    p_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pps_seen |=> !pps_seen);

    p_upper_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && pps_seen) |=>
            (stamp[TS_W-1:HALF] == HALF'($past(stamp[TS_W-1:HALF]) + 1'b1))
            && (stamp[HALF-1:0] == '0));

    p_full_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !(armed && pps_seen) && sample_vld) |=>
            (stamp == TS_W'($past(stamp) + 1'b1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld && !pps_seen) |=> $stable(stamp));

    p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !armed && clr_req) |=> armed);

    p_fire_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && armed && pps_seen) |=> (stamp == '0) && !armed);

    p_armed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && armed && !pps_seen) |=> armed);

    p_secs_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |=> !armed);

endmodule

bind pps_stamp_counter pps_stamp_checker #(
    .TS_W (TS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .mode_sel   (mode_sel),
    .clr_req    (clr_req),
    .stamp      (stamp),
    .pps_seen   (pps_seen),
    .armed      (armed)
);

// File: tb/sim_pps_stamp_counter.sv
module sim_pps_stamp_counter;
    localparam int TS_W = 16;
    localparam int HALF = TS_W / 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n, sample_vld, pps_pin, mode_sel, clr_req;
    logic [TS_W-1:0] stamp;
    logic            pps_seen, armed;

    pps_stamp_counter #(.TS_W(TS_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .pps_pin(pps_pin),
        .mode_sel(mode_sel), .clr_req(clr_req), .stamp(stamp),
        .pps_seen(pps_seen), .armed(armed)
    );

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    // reference state, derived from the requirements
    logic [TS_W-1:0] m_stamp;
    bit              m_armed;
    bit              d1, d2, d3;      // pin as driven 1, 2 and 3 ticks back
    bit              cur_mode, last_mode;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, check the registered result just after the rising edge
    task automatic tick(input bit vld, input bit pin, input bit clr);
        bit    edge_now;
        string tg, atg;
        @(negedge clk);
        sample_vld = vld;
        pps_pin    = pin;
        clr_req    = clr;
        mode_sel   = cur_mode;
        edge_now   = d2 & ~d3;
        chk(pps_seen == edge_now, "R2", "pps_seen", pps_seen, edge_now);
        tg  = "R4";
        atg = clr ? "R7" : "R6";
        if (cur_mode == 1'b0) begin
            if (m_armed) atg = "R9";
            m_armed = 1'b0;
            if (edge_now) begin
                m_stamp[TS_W-1:HALF] = m_stamp[TS_W-1:HALF] + 1'b1;
                m_stamp[HALF-1:0]    = '0;
                tg = vld ? "R5" : "R3";
            end else if (vld) begin
                if (&m_stamp[HALF-1:0]) tg = "R8";
                m_stamp[HALF-1:0] = m_stamp[HALF-1:0] + 1'b1;
            end
        end else begin
            if (m_armed && edge_now) begin
                m_stamp = '0;
                m_armed = 1'b0;
                tg = "R6";
            end else begin
                if (edge_now) tg = "R7";
                if (vld) begin
                    if (&m_stamp[HALF-1:0]) tg = "R8";
                    m_stamp = m_stamp + 1'b1;
                end
                if (!m_armed && clr) begin
                    m_armed = 1'b1;
                    atg = "R6";
                end
            end
        end
        if (cur_mode != last_mode) tg = "R9";
        last_mode = cur_mode;
        d3 = d2; d2 = d1; d1 = pin;
        @(posedge clk);
        #1;
        chk(stamp == m_stamp, tg, "stamp", stamp, m_stamp);
        chk(armed == m_armed, atg, "armed", armed, m_armed);
    endtask

    task automatic pps_pulse(input int width, input bit vld);
        for (int i = 0; i < width; i++) tick(vld, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++)     tick(vld, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sample_vld = 1'b0; pps_pin = 1'b0; mode_sel = 1'b0; clr_req = 1'b0;
        m_stamp = '0; m_armed = 1'b0; d1 = 1'b0; d2 = 1'b0; d3 = 1'b0;
        cur_mode = 1'b0; last_mode = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(stamp == '0, "R1", "stamp after reset", stamp, 0);
        chk(pps_seen == 1'b0, "R1", "pps_seen after reset", pps_seen, 0);
        chk(armed == 1'b0, "R1", "armed after reset", armed, 0);

        // seconds-tag sweep over strobe duty and PPS spacing (R3 R4 R5 R2)
        for (int duty = 1; duty <= 3; duty++) begin
            for (int per = 40; per <= 67; per += 27) begin
                for (int i = 0; i < 200; i++)
                    tick((duty == 1) || ((i % duty) != 0), (i % per) < 3, 1'b0);
            end
        end
        pps_pulse(20, 1'b1);   // long high pin: a single pulse only (R2)
        pps_pulse(1, 1'b1);    // edge on a strobe cycle (R5)
        pps_pulse(2, 1'b0);    // edge with no strobe (R3)
        // seconds-tag lower wrap without carry (R8), clr_req ignored (R7)
        for (int i = 0; i < 300; i++) tick(1'b1, 1'b0, (i % 50) == 7);

        // armed-reset mode
        cur_mode = 1'b1;
        for (int i = 0; i < 30; i++) tick(i[0], 1'b0, 1'b0);
        pps_pulse(2, 1'b1);                            // unarmed edge: no clear (R7)
        tick(1'b1, 1'b0, 1'b1);                         // arm, counter kept (R6)
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, i == 4);  // second request (R7)
        pps_pulse(3, 1'b1);                             // fire with strobe (R6)
        for (int i = 0; i < 300; i++) tick(1'b1, 1'b0, 1'b0);    // carry across halves (R8)
        // request on the same cycle the edge reaches the block while idle
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b0);
        pps_pulse(1, 1'b0);                             // fire without strobe (R6)
        // sweep of arm/fire timing
        for (int k = 0; k < 40; k++) begin
            tick(1'b1, 1'b0, 1'b1);
            for (int j = 0; j < k % 7; j++) tick(j[0], 1'b0, 1'b0);
            pps_pulse(1 + k % 3, k[0]);
        end
        // arm then leave the mode (R9)
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b0);
        cur_mode = 1'b0;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0);
        pps_pulse(1, 1'b1);
        cur_mode = 1'b1;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0);
        pps_pulse(1, 1'b1);    // not armed any more: no clear (R7)

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule